// File: doc/BRIEF.md
# Phase-Frequency Detector with Sense Swap

This block compares two divider outputs of a frequency synthesiser, the divided reference and the divided oscillator, and turns their timing difference into pump-up and pump-down enables for an external charge pump. It is a two-flop phase-frequency detector running on a system clock. Each flop is set by a rising edge from its own input. When both flops are set, a programmable count of clocks elapses and then both flops clear together. Because of this hold-off, both enables pulse briefly even at zero phase error, so there is no dead zone around lock.

A polarity control exchanges the two detector inputs, so that oscillators with either tuning slope can be used. The same control also exchanges the two monitor outputs that echo the divider pulses. A two-bit gain selection is decoded into a registered one-hot multiplier code for the pump current. That code only changes while neither enable is active. A digital lock flag reports when a run of consecutive comparisons has each shown only a small phase excess.

Top module: `pfd_sense_top`

## Requirements
- R1: During and right after reset, `up` and `dn` are low, `gain_oh` is 4'b0001 and `locked` is low.
- R2: With `sense` = 0, a rising edge of `ref_pulse` sampled at a clock edge drives `up` high from that edge, and a rising edge of `vco_pulse` drives `dn` high in the same way.
- R3: Once `up` and `dn` are both high, they stay high together for `rst_dly`+1 clocks and then fall at the same edge. For an input lag of d clocks, the leading enable is therefore high for d+`rst_dly`+1 clocks and the trailing enable for `rst_dly`+1 clocks.
- R4: With `sense` = 1, the roles of the two inputs are exchanged: `vco_pulse` edges drive `up` and `ref_pulse` edges drive `dn`.
- R5: With `sense` = 0, `mon_a` follows `vco_pulse` and `mon_b` follows `ref_pulse` in the same cycle. With `sense` = 1, `mon_a` follows `ref_pulse` and `mon_b` follows `vco_pulse`.
- R6: `gain_oh` has exactly one bit set. `gain_sel` values 0, 1, 2 and 3 (current multipliers ×1, ×1.5, ×2.5 and ×4) map to bit 0, 1, 2 and 3 respectively.
- R7: `gain_oh` takes the decoded `gain_sel` only at a clock edge where both `up` and `dn` are low. While either enable is high, it holds its value.
- R8: `locked` rises after LOCK_CYC (default 16) consecutive comparisons in which the enables differed for fewer than LOCK_THR (default 2) clocks. A comparison with a larger excess drops `locked` at the edge where that comparison clears.
- R9: An input held high counts as a single edge. It does not set its flop again after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | Divided reference pulse |
| vco_pulse | input | 1 | Divided oscillator pulse |
| sense | input | 1 | Polarity: 1 exchanges inputs and monitors |
| gain_sel | input | 2 | Pump current multiplier selection |
| rst_dly | input | DLY_W | Clocks that both flops stay set before clearing, minus one |
| up | output | 1 | Pump-up enable |
| dn | output | 1 | Pump-down enable |
| mon_a | output | 1 | Monitor echo, oscillator side when sense=0 |
| mon_b | output | 1 | Monitor echo, reference side when sense=0 |
| gain_oh | output | 4 | Registered one-hot multiplier code |
| locked | output | 1 | Digital lock indication |

## Verification
A wrong set or clear state in the detector flops appears at once as an enable that is too wide or too narrow. One that fails to clear shows as an enable that never falls. Each of these is visible within a single comparison, `rst_dly`+2 clocks after the lagging edge. A wrong hold-off counter changes both widths by the same amount. A stuck lock counter stays hidden for up to LOCK_CYC comparisons, so the bench runs a full good run, and then a bad one, right after a known reset of the count. A gain register that updates while a pulse is in flight differs at the port on the next clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      GAIN_X1   = 2'd0,
      GAIN_X1P5 = 2'd1,
      GAIN_X2P5 = 2'd2,
      GAIN_X4   = 2'd3
   } gain_sel_e;

   localparam int GAIN_STEPS = 4;

   function automatic logic [GAIN_STEPS-1:0] gain_decode(input logic [1:0] sel);
      logic [GAIN_STEPS-1:0] oh;
      oh = '0;
      for (int i = 0; i < GAIN_STEPS; i++) begin
         if (sel == 2'(i)) oh[i] = 1'b1;
      end
      return oh;
   endfunction
endpackage

// File: rtl/pfd_in_cond.sv
module pfd_in_cond #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise_o
);
   logic lvl;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2+1:0], din} >> 0;
         end
         assign lvl = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise_o = lvl & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_a,
   input  logic             set_b,
   input  logic [DLY_W-1:0] dly,
   output logic             up_o,
   output logic             dn_o,
   output logic             clr_o
);
   logic             up_q, dn_q;
   logic [DLY_W-1:0] hold_cnt;
   logic             both;

   assign both  = up_q & dn_q;
   assign clr_o = both && (hold_cnt == dly);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q     <= 1'b0;
         dn_q     <= 1'b0;
         hold_cnt <= '0;
      end else if (clr_o) begin
         up_q     <= set_a;
         dn_q     <= set_b;
         hold_cnt <= '0;
      end else begin
         up_q     <= up_q | set_a;
         dn_q     <= dn_q | set_b;
         hold_cnt <= both ? hold_cnt + 1'b1 : '0;
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;
endmodule

// File: rtl/pfd_gain.sv
module pfd_gain
   import pfd_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            sel,
   input  logic                  busy,
   output logic [GAIN_STEPS-1:0] oh_o
);
   logic [GAIN_STEPS-1:0] oh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     oh_q <= gain_decode(GAIN_X1);
      else if (!busy) oh_q <= gain_decode(sel);
   end

   assign oh_o = oh_q;
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
   parameter int LOCK_CYC = 16,
   parameter int LOCK_THR = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up,
   input  logic dn,
   input  logic clr,
   output logic locked_o
);
   localparam int EXW = $clog2(LOCK_THR + 1);
   localparam int CW  = $clog2(LOCK_CYC + 1);
   localparam logic [EXW-1:0] EX_MAX  = EXW'(LOCK_THR);
   localparam logic [CW-1:0]  CNT_MAX = CW'(LOCK_CYC);

   logic [EXW-1:0] excess_q;
   logic [CW-1:0]  good_q;
   logic           good_cmp;

   assign good_cmp = (excess_q < EX_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         excess_q <= '0;
         good_q   <= '0;
      end else if (clr) begin
         excess_q <= '0;
         if (!good_cmp)             good_q <= '0;
         else if (good_q != CNT_MAX) good_q <= good_q + 1'b1;
      end else if ((up ^ dn) && (excess_q != EX_MAX)) begin
         excess_q <= excess_q + 1'b1;
      end
   end

   assign locked_o = (good_q == CNT_MAX);
endmodule

// File: rtl/pfd_sense_top.sv
module pfd_sense_top
   import pfd_pkg::*;
#(
   parameter int SYNC_STAGES = 0,
   parameter int DLY_W       = 4,
   parameter int LOCK_CYC    = 16,
   parameter int LOCK_THR    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ref_pulse,
   input  logic                  vco_pulse,
   input  logic                  sense,
   input  logic [1:0]            gain_sel,
   input  logic [DLY_W-1:0]      rst_dly,
   output logic                  up,
   output logic                  dn,
   output logic                  mon_a,
   output logic                  mon_b,
   output logic [GAIN_STEPS-1:0] gain_oh,
   output logic                  locked
);
   generate
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
         $error("DLY_W must lie in 1..16");
      end
      if (LOCK_CYC < 1) begin : g_bad_cyc
         $error("LOCK_CYC must be at least 1");
      end
      if (LOCK_THR < 1) begin : g_bad_thr
         $error("LOCK_THR must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic ref_rise, vco_rise;
   logic set_a, set_b;
   logic clr;

   pfd_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_ref_in (
      .clk(clk), .rst_n(rst_n), .din(ref_pulse), .rise_o(ref_rise)
   );
   pfd_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_vco_in (
      .clk(clk), .rst_n(rst_n), .din(vco_pulse), .rise_o(vco_rise)
   );

   // polarity swap of the detector inputs
   assign set_a = sense ? vco_rise : ref_rise;
   assign set_b = sense ? ref_rise : vco_rise;

   // polarity swap of the monitor echoes
   assign mon_a = sense ? ref_pulse : vco_pulse;
   assign mon_b = sense ? vco_pulse : ref_pulse;

   pfd_core #(.DLY_W(DLY_W)) u_core (
      .clk(clk), .rst_n(rst_n), .set_a(set_a), .set_b(set_b),
      .dly(rst_dly), .up_o(up), .dn_o(dn), .clr_o(clr)
   );

   pfd_gain u_gain (
      .clk(clk), .rst_n(rst_n), .sel(gain_sel), .busy(up | dn), .oh_o(gain_oh)
   );

   pfd_lock #(.LOCK_CYC(LOCK_CYC), .LOCK_THR(LOCK_THR)) u_lock (
      .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .clr(clr), .locked_o(locked)
   );
endmodule

// File: rtl/pfd_sense_chk.sv
module pfd_sense_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_pulse,
   input logic       vco_pulse,
   input logic       sense,
   input logic       up,
   input logic       dn,
   input logic [3:0] gain_oh
);
   // R3
   up_falls_with_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up) |-> $past(dn));

   // R3
   dn_falls_with_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dn) |-> $past(up));

   // R6
   gain_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gain_oh) == 1);

   // R7
   gain_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up || dn) |=> $stable(gain_oh));

   // R2 R4
   up_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up) |-> $past(sense ? vco_pulse : ref_pulse));

   // R2 R4
   dn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn) |-> $past(sense ? ref_pulse : vco_pulse));
endmodule

bind pfd_sense_top pfd_sense_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
   .sense(sense), .up(up), .dn(dn), .gain_oh(gain_oh)
);

// File: tb/tb_pfd_sense_top.sv
module tb_pfd_sense_top;
   localparam int CLK_PERIOD = 10;
   localparam int DLY_W      = 4;
   localparam int LOCK_CYC   = 16;
   localparam int LOCK_THR   = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ref_pulse = 1'b0;
   logic             vco_pulse = 1'b0;
   logic             sense = 1'b0;
   logic [1:0]       gain_sel = 2'd0;
   logic [DLY_W-1:0] rst_dly = '0;
   logic             up, dn, mon_a, mon_b, locked;
   logic [3:0]       gain_oh;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfd_sense_top #(.SYNC_STAGES(0), .DLY_W(DLY_W), .LOCK_CYC(LOCK_CYC), .LOCK_THR(LOCK_THR)) dut (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
      .sense(sense), .gain_sel(gain_sel), .rst_dly(rst_dly),
      .up(up), .dn(dn), .mon_a(mon_a), .mon_b(mon_b), .gain_oh(gain_oh), .locked(locked)
   );

   function automatic logic [3:0] exp_gain(input logic [1:0] s);
      return 4'b0001 << s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // One comparison: leader edge at t=0, lagger at t=d; counts enable widths.
   task automatic compare(input int d, input bit ref_leads, input bit sns,
                          input int dly, input int hold_ref, output int wu, output int wd);
      int win;
      win = d + dly + hold_ref + 8;
      wu = 0; wd = 0;
      sense = sns;
      rst_dly = DLY_W'(dly);
      for (int t = 0; t < win; t++) begin
         @(negedge clk);
         if (up) wu++;
         if (dn) wd++;
         if (ref_leads) begin
            ref_pulse = (t == 0) || (t < hold_ref);
            vco_pulse = (t == d);
         end else begin
            vco_pulse = (t == 0);
            ref_pulse = (t == d) || (t >= d && t < d + hold_ref);
         end
      end
      ref_pulse = 1'b0; vco_pulse = 1'b0;
   endtask

   task automatic check_widths(input int d, input bit ref_leads, input bit sns, input int dly);
      int wu, wd, lead_w, lag_w;
      bit up_leads;
      compare(d, ref_leads, sns, dly, 0, wu, wd);
      up_leads = ref_leads ^ sns;
      lead_w = d + dly + 1;
      lag_w  = dly + 1;
      // R3 with R2 (sense=0) or R4 (sense=1)
      check(wu == (up_leads ? lead_w : lag_w), sns ? "R4 up width" : "R3 up width", wu, up_leads ? lead_w : lag_w);
      check(wd == (up_leads ? lag_w : lead_w), sns ? "R4 dn width" : "R3 dn width", wd, up_leads ? lag_w : lead_w);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int wu, wd;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset values
      check(up == 0 && dn == 0, "R1 enables", {up, dn}, 0);
      check(gain_oh == 4'b0001, "R1 gain", gain_oh, 1);
      check(locked == 0, "R1 locked", locked, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(up == 0 && dn == 0 && gain_oh == 4'b0001 && !locked, "R1 after release", {up, dn, gain_oh, locked}, 2);

      // R2 directed: reference leads by 3, no hold-off
      check_widths(3, 1'b1, 1'b0, 0);
      check_widths(0, 1'b1, 1'b0, 2);
      check_widths(4, 1'b0, 1'b0, 1);
      // R4 directed
      check_widths(3, 1'b1, 1'b1, 0);
      check_widths(2, 1'b0, 1'b1, 3);

      // R9: reference held high for 10 clocks, oscillator edge at 3
      compare(3, 1'b1, 1'b0, 1, 10, wu, wd);
      check(wu == 5, "R9 up width held input", wu, 5);
      check(wd == 2, "R9 dn width held input", wd, 2);

      // R5 monitor swap
      for (int s = 0; s < 2; s++) begin
         @(negedge clk);
         sense = s[0]; ref_pulse = 1'b1; vco_pulse = 1'b0;
         #1;
         check(mon_a == s[0] && mon_b == !s[0], "R5 monitors ref high", {mon_a, mon_b}, s[0] ? 2 : 1);
         ref_pulse = 1'b0; vco_pulse = 1'b1;
         #1;
         check(mon_a == !s[0] && mon_b == s[0], "R5 monitors vco high", {mon_a, mon_b}, s[0] ? 1 : 2);
         ref_pulse = 1'b0; vco_pulse = 1'b0;
         repeat (8) @(negedge clk);
      end
      sense = 1'b0;

      // R6 decode while idle
      for (int g = 0; g < 4; g++) begin
         @(negedge clk);
         gain_sel = 2'(g);
         @(negedge clk);
         check(gain_oh == exp_gain(2'(g)), "R6 gain decode", gain_oh, exp_gain(2'(g)));
      end

      // R7 gain held while up is active
      @(negedge clk);
      gain_sel = 2'd1; rst_dly = DLY_W'(1); sense = 1'b0;
      @(negedge clk);
      check(gain_oh == 4'b0010, "R7 gain idle update", gain_oh, 2);
      ref_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0;
      gain_sel = 2'd3;
      repeat (3) @(negedge clk);
      check(up == 1, "R7 up pending", up, 1);
      check(gain_oh == 4'b0010, "R7 gain held while busy", gain_oh, 2);
      vco_pulse = 1'b1;
      @(negedge clk);
      vco_pulse = 1'b0;
      @(negedge clk);
      check(gain_oh == 4'b0010, "R7 gain held in hold-off", gain_oh, 2);
      repeat (3) @(negedge clk);
      check(up == 0 && dn == 0, "R3 clear after hold-off", {up, dn}, 0);
      check(gain_oh == 4'b1000, "R7 gain after clear", gain_oh, 8);

      // R8 lock run
      compare(4, 1'b1, 1'b0, 0, 0, wu, wd);
      check(locked == 0, "R8 unlocked after wide", locked, 0);
      for (int i = 0; i < LOCK_CYC; i++) begin
         compare(i % LOCK_THR, i[0], 1'b0, 1, 0, wu, wd);
         if (i == LOCK_CYC - 2) check(locked == 0, "R8 not yet locked", locked, 0);
      end
      check(locked == 1, "R8 locked after run", locked, 1);
      compare(LOCK_THR, 1'b1, 1'b0, 0, 0, wu, wd);
      check(locked == 0, "R8 lock lost on excess", locked, 0);

      // R3 R4 random comparisons
      for (int k = 0; k < 60; k++) begin
         check_widths(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), int'($urandom_range(0, 4)));
      end

      summary();
   end
endmodule